// File: doc/BRIEF.md
# Circular Descriptor Chain Walker

This block drives a DMA channel from a ring of transfer descriptors held in system memory. Each descriptor is three consecutive 32-bit little-endian words. The word at offset 0 is the byte count, offset 4 holds the buffer address, and offset 8 holds the address of the following descriptor. After `start`, the walker reads the three words of the descriptor at the loaded head address over a read-request/response port. It hands the buffer address and count to an external transfer sequencer and waits for that sequencer to report completion. It then pulses `link_done` and follows the next pointer.

The last descriptor points back to the head, so the walk never ends on its own. It runs until `stop` or `abort` arrives, or until a memory read returns an error. `stop` lets the descriptor in flight finish, including its link-complete pulse, and then idles. `abort` idles on the next clock with no draining. A free-running device byte counter adds the byte count of every data beat that the sequencer reports. Software can zero it with `cnt_clear`.

Both outgoing requests use valid/ready. `mem_req_valid` with `mem_req_addr`, and `xfer_valid` with `xfer_addr`/`xfer_count`, stay asserted and unchanged until the matching ready is seen high at a clock edge. `abort` is the only way to withdraw a request that has not been accepted. The walker has at most one memory read in flight. It takes a response in any cycle in which `mem_rsp_valid` is high while a read is outstanding, so the response channel has no back-pressure. A response that arrives with no read outstanding, for example after an abort, is discarded.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset, `busy`, `link_done`, `xfer_err`, `mem_req_valid` and `xfer_valid` are low, and `dev_bytes` is zero.
- R2: A `start` seen while idle latches `head_addr` and makes `busy` high on the next cycle. The walker then reads the descriptor words in increasing address order: count at base+0, buffer address at base+4, next pointer at base+8. Each word is taken as is, with byte lane k (bits 8k+7:8k) belonging to address base+k.
- R3: While `mem_req_valid` is high and `mem_req_ready` low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged. Only one read is outstanding, and each response is bound to the oldest outstanding read.
- R4: For a descriptor with a nonzero count, `xfer_valid` presents that descriptor's buffer address and count, held stable until `xfer_ready`. `xfer_done` is acted on only after the command has been accepted.
- R5: After `xfer_done` for a descriptor, `link_done` is high for exactly one cycle. The next fetch then starts at that descriptor's next pointer.
- R6: When the next pointer leads back to the head, the walker keeps fetching around the ring indefinitely.
- R7: A descriptor whose count is zero issues no transfer command. It still produces one `link_done` pulse, and the walker proceeds to its next pointer.
- R8: `stop` while busy lets the current descriptor finish with its `link_done` pulse, then returns to idle without fetching any further descriptor. A `stop` sampled in the link-complete cycle takes effect at that boundary.
- R9: `abort` returns the walker to idle on the next cycle from any state, with no `link_done`. A memory response that arrives later is ignored.
- R10: A response with `mem_rsp_err` high sets `xfer_err` and idles the walker. `xfer_err` stays high until the next accepted `start`, which clears it.
- R11: `dev_bytes` adds `beat_bytes` in each cycle with `beat_valid` and wraps modulo 2^CNT_W. `cnt_clear` zeroes it; when a beat arrives in the same cycle, the result equals that beat's byte count.
- R12: `start` while busy is ignored: the ring in progress continues from its own next pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking from `head_addr` (honoured when idle) |
| stop | input | 1 | Finish current descriptor, then idle |
| abort | input | 1 | Idle at once, no draining |
| head_addr | input | AW | Address of the first descriptor |
| mem_req_valid | output | 1 | Descriptor word read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | AW | Byte address of the 32-bit word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data, little-endian |
| mem_rsp_err | input | 1 | Read failed |
| xfer_valid | output | 1 | Transfer command valid |
| xfer_ready | input | 1 | Sequencer accepts the command |
| xfer_addr | output | AW | Buffer address of the descriptor |
| xfer_count | output | CW | Byte count of the descriptor |
| beat_valid | input | 1 | Sequencer moved a data beat |
| beat_bytes | input | BEAT_W | Bytes in that beat |
| xfer_done | input | 1 | Sequencer finished the accepted command |
| link_done | output | 1 | One-cycle link-complete event |
| busy | output | 1 | Walker is not idle |
| xfer_err | output | 1 | Sticky memory read error |
| cnt_clear | input | 1 | Zero the device byte counter |
| dev_bytes | output | CNT_W | Device byte counter |

## Verification
The bench sweeps rings of one to four descriptors. These include a short final descriptor and a zero-count descriptor at several positions, with varying memory latency and ready patterns. Every read address and every transfer command is compared with values computed from the ring layout. A walker that mixed up word offsets, or that bound a response to the wrong read, would send wrong addresses or counts to the sequencer. A walker that failed to close the ring would lose the address sequence after the first lap. Stop is issued both inside and on the link-complete cycle: a design that stopped early or late would show one link event too few or one too many, or fetch a descriptor beyond the stop. Further cases cover an abort with a response still outstanding, where a design that accepted the stale word would corrupt the next run. A read error must halt the walker and be cleared by a fresh start. A counter clear coinciding with a beat would, if mishandled, either drop the beat or keep the old total.

// File: rtl/drw_pkg.sv
package drw_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_WORDS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FCNT,
    ST_FADDR,
    ST_FNEXT,
    ST_XFER,
    ST_LDONE
  } drw_state_e;
endpackage

// File: rtl/drw_mem_reader.sv
module drw_mem_reader #(
  parameter int AW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      fetch_en,
  input  logic [AW-1:0]             fetch_addr,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [AW-1:0]             mem_req_addr,
  input  logic                      mem_rsp_valid,
  input  logic [drw_pkg::WORD_W-1:0] mem_rsp_data,
  input  logic                      mem_rsp_err,
  output logic                      word_valid,
  output logic [drw_pkg::WORD_W-1:0] word_data,
  output logic                      word_err
);
  logic pend_q;

  assign mem_req_valid = fetch_en && !pend_q;
  assign mem_req_addr  = fetch_addr;
  assign word_valid    = pend_q && mem_rsp_valid;
  assign word_data     = mem_rsp_data;
  assign word_err      = mem_rsp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              pend_q <= 1'b0;
    else if (flush)                          pend_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
    else if (word_valid)                     pend_q <= 1'b0;
  end

  // R3: an unaccepted read request is held with its address
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || flush)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R3: a response is only consumed while the controller is fetching
  p_rsp_in_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> fetch_en);
endmodule

// File: rtl/drw_byte_counter.sv
module drw_byte_counter #(
  parameter int CNT_W  = 32,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_clear,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_bytes,
  output logic [CNT_W-1:0]  dev_bytes
);
  logic [CNT_W-1:0] add_w;

  assign add_w = beat_valid ? CNT_W'(beat_bytes) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dev_bytes <= '0;
    else if (cnt_clear) dev_bytes <= add_w;
    else                dev_bytes <= dev_bytes + add_w;
  end

  // R11: clearing keeps only the beat of the clearing cycle
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> dev_bytes == ($past(beat_valid) ? CNT_W'($past(beat_bytes)) : '0));

  // R11: with no beat and no clear the count holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear && !beat_valid |=> $stable(dev_bytes));
endmodule

// File: rtl/drw_ctrl.sv
module drw_ctrl
  import drw_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              abort,
  input  logic [AW-1:0]     head_addr,
  output logic              fetch_en,
  output logic [AW-1:0]     fetch_addr,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_err,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [AW-1:0]     xfer_addr,
  output logic [CW-1:0]     xfer_count,
  input  logic              xfer_done,
  output logic              link_done,
  output logic              busy,
  output logic              xfer_err
);
  drw_state_e    state_q;
  logic [AW-1:0] base_q, addr_q, next_q;
  logic [CW-1:0] cnt_q;
  logic          cmd_sent_q, stop_pend_q, err_q;
  logic [1:0]    widx;
  logic          in_fetch;

  always_comb begin
    in_fetch = 1'b1;
    widx     = 2'd0;
    unique case (state_q)
      ST_FCNT:  widx = 2'd0;
      ST_FADDR: widx = 2'd1;
      ST_FNEXT: widx = 2'd2;
      default:  in_fetch = 1'b0;
    endcase
  end

  assign fetch_en   = in_fetch;
  assign fetch_addr = base_q + AW'(widx) * AW'(WORD_BYTES);
  assign xfer_valid = (state_q == ST_XFER) && !cmd_sent_q;
  assign xfer_addr  = addr_q;
  assign xfer_count = cnt_q;
  assign link_done  = (state_q == ST_LDONE);
  assign busy       = (state_q != ST_IDLE);
  assign xfer_err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      base_q      <= '0;
      addr_q      <= '0;
      next_q      <= '0;
      cnt_q       <= '0;
      cmd_sent_q  <= 1'b0;
      stop_pend_q <= 1'b0;
      err_q       <= 1'b0;
    end else if (abort) begin
      state_q     <= ST_IDLE;
      cmd_sent_q  <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (in_fetch && word_valid && word_err) begin
      state_q     <= ST_IDLE;
      err_q       <= 1'b1;
      stop_pend_q <= 1'b0;
    end else begin
      if (stop && state_q != ST_IDLE) stop_pend_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q     <= ST_FCNT;
          base_q      <= head_addr;
          err_q       <= 1'b0;
          stop_pend_q <= 1'b0;
        end
        ST_FCNT: if (word_valid) begin
          cnt_q   <= word_data[CW-1:0];
          state_q <= ST_FADDR;
        end
        ST_FADDR: if (word_valid) begin
          addr_q  <= word_data[AW-1:0];
          state_q <= ST_FNEXT;
        end
        ST_FNEXT: if (word_valid) begin
          next_q  <= word_data[AW-1:0];
          state_q <= (cnt_q == '0) ? ST_LDONE : ST_XFER;
        end
        ST_XFER: begin
          if (!cmd_sent_q) begin
            if (xfer_ready) cmd_sent_q <= 1'b1;
          end else if (xfer_done) begin
            cmd_sent_q <= 1'b0;
            state_q    <= ST_LDONE;
          end
        end
        ST_LDONE: begin
          if (stop_pend_q || stop) begin
            state_q     <= ST_IDLE;
            stop_pend_q <= 1'b0;
          end else begin
            base_q  <= next_q;
            state_q <= ST_FCNT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: nothing is requested while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fetch_en && !xfer_valid && !link_done);

  // R4: a pending command keeps its address and count
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || abort)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_count));

  // R5: link-complete lasts a single cycle
  p_link_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_done |=> !link_done);

  // R7: an empty descriptor never reaches the sequencer
  p_zero_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_count != '0);

  // R8: stop seen at the link boundary ends the walk
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n || abort)
    link_done && stop |=> !busy);

  // R9: abort idles the walker on the next cycle
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !link_done);

  // R10: a newly raised error leaves the walker idle
  p_err_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_err) |-> !busy);
endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker
  import drw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 32,
  parameter int BEAT_W = 3,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              abort,
  input  logic [AW-1:0]     head_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [AW-1:0]     xfer_addr,
  output logic [CW-1:0]     xfer_count,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic              xfer_done,
  output logic              link_done,
  output logic              busy,
  output logic              xfer_err,
  input  logic              cnt_clear,
  output logic [CNT_W-1:0]  dev_bytes
);
  logic              fetch_en;
  logic [AW-1:0]     fetch_addr;
  logic              word_valid;
  logic [WORD_W-1:0] word_data;
  logic              word_err;

  drw_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stop       (stop),
    .abort      (abort),
    .head_addr  (head_addr),
    .fetch_en   (fetch_en),
    .fetch_addr (fetch_addr),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_err   (word_err),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .xfer_addr  (xfer_addr),
    .xfer_count (xfer_count),
    .xfer_done  (xfer_done),
    .link_done  (link_done),
    .busy       (busy),
    .xfer_err   (xfer_err)
  );

  drw_mem_reader #(.AW(AW)) u_reader (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (abort),
    .fetch_en      (fetch_en),
    .fetch_addr    (fetch_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err),
    .word_valid    (word_valid),
    .word_data     (word_data),
    .word_err      (word_err)
  );

  drw_byte_counter #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_clear  (cnt_clear),
    .beat_valid (beat_valid),
    .beat_bytes (beat_bytes),
    .dev_bytes  (dev_bytes)
  );

  // R2: a start while idle makes the walker busy on the next cycle
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n || abort)
    !busy && start |=> busy);

  // R12: a start while busy does not reset the fetch address
  p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n || abort)
    busy && start && mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));
endmodule

// File: tb/desc_ring_walker_test.sv
`timescale 1ns/1ps
module desc_ring_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, stop = 0, abort = 0, cnt_clear = 0;
  logic [31:0] head_addr = '0;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [31:0] mem_rsp_data = '0;
  logic        xfer_valid, xfer_ready = 0, xfer_done = 0;
  logic [31:0] xfer_addr, xfer_count;
  logic        beat_valid = 0;
  logic [2:0]  beat_bytes = '0;
  logic        link_done, busy, xfer_err;
  logic [31:0] dev_bytes;

  always #4 clk = ~clk;

  desc_ring_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .abort(abort),
    .head_addr(head_addr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_addr(xfer_addr), .xfer_count(xfer_count), .beat_valid(beat_valid),
    .beat_bytes(beat_bytes), .xfer_done(xfer_done), .link_done(link_done), .busy(busy),
    .xfer_err(xfer_err), .cnt_clear(cnt_clear), .dev_bytes(dev_bytes)
  );

  int tests = 0, fails = 0;
  int cyc = 0, seed = 0, err_addr = -1;
  int n_cur = 1, h_cur = 0;
  int cnt_tab [4];
  logic [31:0] mem [256];
  int walk = 0, wsel = 0, fetched = 0, links = 0;
  bit m_fire = 0, s_fire = 0, s_active = 0;
  logic [31:0] m_addr, rsp_addr, s_addr_l, s_cnt_l;
  int rsp_wait = -1, s_left = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dbuf(int i);
    return 32'h1000 * (i + 1) + 32'h10 * n_cur;
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // memory and sequencer models, driven away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (link_done) links++;
      // memory
      mem_rsp_valid = 0;
      mem_rsp_err   = 0;
      if (m_fire) begin
        logic [31:0] e;
        e = h_cur + 16 * walk + 4 * wsel;
        if (walk == 0 && fetched > 0) chk(m_addr == e, "R6 ring wrap fetch", m_addr, e);
        else                          chk(m_addr == e, "R2 fetch address", m_addr, e);
        wsel++;
        if (wsel == 3) begin wsel = 0; walk = (walk + 1) % n_cur; fetched++; end
        rsp_addr = m_addr;
        rsp_wait = seed % 3;
        m_fire = 0;
      end
      if (rsp_wait == 0) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = mem[rsp_addr[9:2]];
        mem_rsp_err   = (int'(rsp_addr) == err_addr);
        rsp_wait = -1;
      end else if (rsp_wait > 0) rsp_wait--;
      mem_req_ready = ((cyc + seed) % 4) != 3;
      m_fire = mem_req_valid && mem_req_ready;
      m_addr = mem_req_addr;
      // sequencer
      beat_valid = 0;
      xfer_done  = 0;
      if (s_fire) begin
        int d;
        d = (walk + n_cur - 1) % n_cur;
        chk(s_addr_l == dbuf(d), "R4 command address", s_addr_l, dbuf(d));
        chk(s_cnt_l == cnt_tab[d], "R4 command count", s_cnt_l, cnt_tab[d]);
        chk(cnt_tab[d] != 0, "R7 no command for empty descriptor", s_cnt_l, 0);
        s_left = int'(s_cnt_l);
        s_active = 1;
        s_fire = 0;
      end else if (s_active) begin
        if (s_left > 0) begin
          int b;
          b = (s_left > 4) ? 4 : s_left;
          beat_valid = 1;
          beat_bytes = 3'(b);
          s_left -= b;
        end else begin
          xfer_done = 1;
          s_active = 0;
        end
      end
      xfer_ready = ((cyc + seed) % 3) != 1;
      s_fire = xfer_valid && xfer_ready;
      s_addr_l = xfer_addr;
      s_cnt_l  = xfer_count;
    end
  end

  task automatic prep(int n, int rem, int zat, int sd);
    repeat (40) step();
    seed = sd;
    n_cur = n;
    h_cur = 'h40 + 'h40 * (sd % 3);
    for (int i = 0; i < n; i++) begin
      int b;
      cnt_tab[i] = (i == n - 1 && rem != 0) ? rem : 64;
      if (i == zat) cnt_tab[i] = 0;
      b = (h_cur + 16 * i) >> 2;
      mem[b]     = cnt_tab[i];
      mem[b + 1] = dbuf(i);
      mem[b + 2] = (i == n - 1) ? h_cur : h_cur + 16 * (i + 1);
    end
    walk = 0; wsel = 0; fetched = 0; links = 0;
    cnt_clear = 1;
    step();
    cnt_clear = 0;
    chk(dev_bytes == 0, "R11 clear", dev_bytes, 0);
  endtask

  task automatic kick();
    head_addr = h_cur;
    start = 1;
    step();
    start = 0;
    chk(busy, "R2 busy after start", busy, 1);
  endtask

  task automatic halt_and_check(bit check_bytes);
    int expl, sum;
    expl = links + (link_done ? 0 : 1);
    stop = 1;
    step();
    stop = 0;
    while (busy) step();
    chk(links == expl, "R8 link events at stop", links, expl);
    chk(fetched == links, "R8 no fetch beyond stop", fetched, links);
    if (check_bytes) begin
      sum = 0;
      for (int k = 0; k < links; k++) sum += cnt_tab[k % n_cur];
      chk(dev_bytes == sum, "R11 byte total", dev_bytes, sum);
    end
  endtask

  task automatic run_ring(int n, int rem, int zat, int sd, bit ign);
    prep(n, rem, zat, sd);
    kick();
    if (ign) begin
      while (links < 1) step();
      head_addr = 'h300;
      start = 1;
      step();
      start = 0;
    end
    while (links < 2 * n) step();
    halt_and_check(1);
    chk(xfer_err == 0, "R5 no error on clean ring", xfer_err, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!busy && !link_done && !xfer_err, "R1 idle after reset", {busy, link_done, xfer_err}, 0);
    chk(!mem_req_valid && !xfer_valid, "R1 no requests after reset", {mem_req_valid, xfer_valid}, 0);
    chk(dev_bytes == 0, "R1 counter after reset", dev_bytes, 0);

    for (int n = 1; n <= 4; n++)
      for (int ri = 0; ri < 4; ri++)
        for (int z = 0; z < 2; z++) begin
          int rems [4] = '{0, 1, 3, 37};
          run_ring(n, rems[ri], z ? (ri % n) : -1, n * 8 + ri * 2 + z, (n == 3 && ri == 1 && z == 0));
        end

    // read error on the address word of the second descriptor
    prep(3, 0, -1, 5);
    err_addr = h_cur + 16 + 4;
    kick();
    while (busy) step();
    chk(xfer_err == 1, "R10 error flag", xfer_err, 1);
    chk(links == 1, "R10 halt after error", links, 1);
    err_addr = -1;
    repeat (10) step();
    chk(xfer_err == 1, "R10 error is sticky", xfer_err, 1);
    walk = 0; wsel = 0; fetched = 0; links = 0;
    kick();
    chk(xfer_err == 0, "R10 start clears error", xfer_err, 0);
    halt_and_check(0);

    // abort during a transfer
    prep(3, 0, -1, 7);
    kick();
    while (!s_active) step();
    begin
      int l0;
      l0 = links;
      abort = 1;
      step();
      abort = 0;
      chk(!busy, "R9 abort in transfer", busy, 0);
      repeat (60) step();
      chk(links == l0, "R9 no link event after abort", links, l0);
    end

    // abort with a read still outstanding (latency 2)
    prep(3, 0, -1, 2);
    kick();
    while (!(rsp_wait > 0)) step();
    abort = 1;
    step();
    abort = 0;
    chk(!busy, "R9 abort in fetch", busy, 0);
    repeat (10) step();
    chk(!mem_req_valid && links == 0, "R9 stale response ignored", {mem_req_valid, 8'(links)}, 0);
    // a fresh run must not see the stale word
    run_ring(2, 5, -1, 2, 0);

    // clear in the same cycle as a beat
    prep(2, 0, -1, 4);
    kick();
    while (!beat_valid) step();
    begin
      logic [31:0] b;
      b = 32'(beat_bytes);
      cnt_clear = 1;
      step();
      cnt_clear = 0;
      chk(dev_bytes == b, "R11 clear with beat", dev_bytes, b);
    end
    abort = 1;
    step();
    abort = 0;
    repeat (60) step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog on R5 progress actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule